// File: doc/BRIEF.md
# Hardware Thread Run-Queue Scheduler

This block picks which hardware thread a barrel processor issues next. It manages thread identifiers from allocation to release. Unused identifiers sit in a first-in first-out free pool. An allocation bitmap records which identifiers are live. Runnable threads form a circular singly linked list. Three commands drive it: a create request takes an identifier from the pool, an enqueue request links an allocated thread into the rotation, and a delete request unlinks a thread and returns its identifier to the pool.

Every cycle an issue pointer sits on one list entry. When that thread is runnable and not already in flight in the pipeline, the block offers it on the issue port and then moves to the successor. A thread still in the pipeline holds the pointer for a cycle, and the same thread is retried. Deleting a thread leaves that entry's own link untouched. If the pointer rests on a thread that has just been removed, it follows that stale link to a live thread on the next cycle.

The issue port has a valid flag and no ready input. The only back-pressure is the per-thread `in_pipe` mask, which stalls the pointer as described. Commands are single-cycle strobes. The create result comes back as a one-cycle `create_done` pulse.

Top module: `thread_sched`

## Requirements
- R1: After reset, `issue_valid` and `create_done` are 0. Successive creates return identifiers 0, 1, 2, … up to NTHR-1 in that order.
- R2: A successful create pulses `create_done` with `create_fail`=0 in the cycle after the request. It does not make the thread issuable, so `issue_valid` stays 0 until an enqueue.
- R3: An enqueue appends the thread at the tail of the rotation. Threads that are never stalled are offered one per cycle, in the order they were enqueued, repeating.
- R4: While the thread under the issue pointer has its `in_pipe` bit set, `issue_valid` is 0. That same thread is offered in the first cycle its bit is clear.
- R5: A delete removes the thread from the rotation and appends its identifier to the tail of the free pool. Later creates hand identifiers back in the order they were freed.
- R6: If the issue pointer rests on a thread that is deleted, the next cycle shows `issue_valid`=0. The cycle after that offers the deleted thread's former successor.
- R7: A create with an empty free pool pulses `create_done` with `create_fail`=1 and changes no state.
- R8: With no thread in the rotation, `issue_valid` is 0.
- R9: At most one command acts per cycle. Priority is delete, then enqueue, then create, counting only requests that are valid. A create that loses gives no `create_done` pulse.
- R10: Three requests are ignored: an enqueue of an unallocated identifier, an enqueue of an identifier already in the rotation, and a delete of an unallocated identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| create_req | input | 1 | Request a fresh thread identifier |
| create_done | output | 1 | One-cycle pulse answering a create |
| create_fail | output | 1 | Qualifies `create_done`: pool was empty |
| create_tid | output | TW | Identifier handed out by a successful create |
| enq_req | input | 1 | Append `enq_tid` to the rotation |
| enq_tid | input | TW | Thread to enqueue |
| del_req | input | 1 | Delete `del_tid` |
| del_tid | input | TW | Thread to delete |
| in_pipe | input | NTHR | One bit per thread, set while that thread is in flight |
| issue_valid | output | 1 | `issue_tid` is offered for issue this cycle |
| issue_tid | output | TW | Thread under the issue pointer |

## Verification
The rotation is first tried with three threads that are never stalled. This shows that enqueue order sets issue order. A stall on the middle thread then tells a retry apart from a skip, because the thread offered after the stall must be the stalled one and not its successor. Deleting the thread the pointer is parked on separates following the stale link from losing the rotation. Duplicate and illegal commands are followed by a watch of the rotation and of the identifiers that creates return, and that watch would expose a doubled link or a pool entry pushed twice.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_CREATE = 2'd1,
    CMD_ENQ    = 2'd2,
    CMD_DEL    = 2'd3
  } ts_cmd_e;
endpackage

// File: rtl/ts_free_fifo.sv
module ts_free_fifo #(
  parameter int N  = 8,
  parameter int TW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [TW-1:0] push_id,
  output logic [TW-1:0] head_id,
  output logic          empty,
  output logic [CW-1:0] cnt
);
  logic [TW-1:0] slot [N];
  logic [TW-1:0] rd_p, wr_p;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] p);
    return (p == TW'(N-1)) ? '0 : p + 1'b1;
  endfunction

  assign head_id = slot[rd_p];
  assign empty   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) slot[i] <= TW'(i);
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= CW'(N);
    end else begin
      if (push) begin
        slot[wr_p] <= push_id;
        wr_p       <= wrap_inc(wr_p);
      end
      if (pop) rd_p <= wrap_inc(rd_p);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(N))); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
endmodule

// File: rtl/ts_runq.sv
module ts_runq #(
  parameter int N  = 8,
  parameter int TW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_go,
  input  logic [TW-1:0] enq_id,
  input  logic          del_go,
  input  logic [TW-1:0] del_id,
  input  logic [N-1:0]  in_pipe,
  output logic [N-1:0]  in_q,
  output logic          issue_valid,
  output logic [TW-1:0] issue_tid
);
  logic [TW-1:0] nxt   [N];
  logic [TW-1:0] nxt_d [N];
  logic [N-1:0]  in_q_d, pred_hit;
  logic [TW-1:0] tail, tail_d, cur, cur_d, pred;
  logic [CW-1:0] qcnt, qcnt_d;
  logic          stall;

  for (genvar g = 0; g < N; g++) begin : g_pred
    assign pred_hit[g] = in_q[g] && (nxt[g] == del_id) && (TW'(g) != del_id);
  end

  always_comb begin
    pred = '0;
    for (int i = 0; i < N; i++) if (pred_hit[i]) pred = TW'(i);
  end

  assign stall       = in_q[cur] && in_pipe[cur];
  assign issue_valid = in_q[cur] && !in_pipe[cur];
  assign issue_tid   = cur;

  always_comb begin
    for (int i = 0; i < N; i++) nxt_d[i] = nxt[i];
    in_q_d = in_q;
    tail_d = tail;
    qcnt_d = qcnt;
    if (enq_go) begin
      if (qcnt == '0) begin
        nxt_d[enq_id] = enq_id;
      end else begin
        nxt_d[enq_id] = nxt[tail];
        nxt_d[tail]   = enq_id;
      end
      tail_d         = enq_id;
      in_q_d[enq_id] = 1'b1;
      qcnt_d         = qcnt + 1'b1;
    end else if (del_go && in_q[del_id]) begin
      in_q_d[del_id] = 1'b0;
      qcnt_d         = qcnt - 1'b1;
      if (qcnt != CW'(1)) begin
        nxt_d[pred] = nxt[del_id];
        if (tail == del_id) tail_d = pred;
      end
    end
    if (enq_go && qcnt == '0) cur_d = enq_id;
    else if (stall)           cur_d = cur;
    else                      cur_d = nxt_d[cur];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) nxt[i] <= TW'(i);
      in_q <= '0;
      tail <= '0;
      cur  <= '0;
      qcnt <= '0;
    end else begin
      for (int i = 0; i < N; i++) nxt[i] <= nxt_d[i];
      in_q <= in_q_d;
      tail <= tail_d;
      cur  <= cur_d;
      qcnt <= qcnt_d;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (cur == $past(cur))); // R4
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt == '0) |-> !issue_valid); // R8
  AST_PRED_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pred_hit)); // R6
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_q) == int'(qcnt)); // R3
endmodule

// File: rtl/thread_sched.sv
module thread_sched #(
  parameter int NTHR = 8,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            create_req,
  output logic            create_done,
  output logic            create_fail,
  output logic [TW-1:0]   create_tid,
  input  logic            enq_req,
  input  logic [TW-1:0]   enq_tid,
  input  logic            del_req,
  input  logic [TW-1:0]   del_tid,
  input  logic [NTHR-1:0] in_pipe,
  output logic            issue_valid,
  output logic [TW-1:0]   issue_tid
);
  import ts_pkg::*;
  localparam int CW = $clog2(NTHR + 1);

  logic [NTHR-1:0] alloc, in_q;
  logic [TW-1:0]   pool_head;
  logic            pool_empty;
  logic [CW-1:0]   pool_cnt;
  ts_cmd_e         cmd;
  logic            do_pop, do_push;

  always_comb begin
    if (del_req && alloc[del_tid])                      cmd = CMD_DEL;
    else if (enq_req && alloc[enq_tid] && !in_q[enq_tid]) cmd = CMD_ENQ;
    else if (create_req)                                cmd = CMD_CREATE;
    else                                                cmd = CMD_NONE;
  end

  assign do_pop  = (cmd == CMD_CREATE) && !pool_empty;
  assign do_push = (cmd == CMD_DEL);

  ts_free_fifo #(.N(NTHR), .TW(TW), .CW(CW)) u_pool (
    .clk(clk), .rst_n(rst_n), .pop(do_pop), .push(do_push),
    .push_id(del_tid), .head_id(pool_head), .empty(pool_empty), .cnt(pool_cnt)
  );

  ts_runq #(.N(NTHR), .TW(TW), .CW(CW)) u_runq (
    .clk(clk), .rst_n(rst_n),
    .enq_go(cmd == CMD_ENQ), .enq_id(enq_tid),
    .del_go(cmd == CMD_DEL), .del_id(del_tid),
    .in_pipe(in_pipe), .in_q(in_q),
    .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc       <= '0;
      create_done <= 1'b0;
      create_fail <= 1'b0;
      create_tid  <= '0;
    end else begin
      create_done <= (cmd == CMD_CREATE);
      create_fail <= (cmd == CMD_CREATE) && pool_empty;
      if (do_pop) begin
        alloc[pool_head] <= 1'b1;
        create_tid       <= pool_head;
      end
      if (do_push) alloc[del_tid] <= 1'b0;
    end
  end

  AST_QUEUED_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q & ~alloc) == '0); // R10
  AST_ISSUE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> alloc[issue_tid]); // R3
  AST_ID_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pool_cnt) + $countones(alloc)) == NTHR); // R5
  AST_CREATE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (create_req && !del_req && !enq_req && pool_empty) |=> (create_done && create_fail)); // R7
  AST_DEL_BEATS_CREATE: assert property (@(posedge clk) disable iff (!rst_n)
    (del_req && alloc[del_tid] && create_req) |=> !create_done); // R9
endmodule

// File: tb/sim_thread_sched.sv
`timescale 1ns/1ps
module sim_thread_sched;
  localparam int NTHR = 8;
  localparam int TW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            create_req = 1'b0, enq_req = 1'b0, del_req = 1'b0;
  logic [TW-1:0]   enq_tid = '0, del_tid = '0;
  logic [NTHR-1:0] in_pipe = '0;
  logic            create_done, create_fail, issue_valid;
  logic [TW-1:0]   create_tid, issue_tid;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thread_sched #(.NTHR(NTHR)) u0 (
    .clk(clk), .rst_n(rst_n), .create_req(create_req), .create_done(create_done),
    .create_fail(create_fail), .create_tid(create_tid), .enq_req(enq_req),
    .enq_tid(enq_tid), .del_req(del_req), .del_tid(del_tid), .in_pipe(in_pipe),
    .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic create_expect(string r, bit exp_fail, int exp_tid);
    @(posedge clk); #1 create_req = 1'b1;
    @(posedge clk); #1 create_req = 1'b0;
    chk(r, int'(create_done), 1);
    chk(r, int'(create_fail), int'(exp_fail));
    if (!exp_fail) chk(r, int'(create_tid), exp_tid);
  endtask

  task automatic enq_cmd(int t);
    @(posedge clk); #1 enq_req = 1'b1; enq_tid = TW'(t);
    @(posedge clk); #1 enq_req = 1'b0;
  endtask

  task automatic del_cmd(int t);
    @(posedge clk); #1 del_req = 1'b1; del_tid = TW'(t);
    @(posedge clk); #1 del_req = 1'b0;
  endtask

  task automatic wait_for(int t);
    bit hit = 1'b0;
    for (int k = 0; k < 12 && !hit; k++) begin
      @(negedge clk);
      hit = issue_valid && (int'(issue_tid) == t);
    end
    chk("R3 reach thread", int'(hit), 1);
  endtask

  // every cycle valid, only ids in mask, alternate when two members
  task automatic check_rot(string r, logic [NTHR-1:0] mask, bit alt);
    int prev = -1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(r, int'(issue_valid), 1);
      chk(r, int'(mask[issue_tid]), 1);
      if (alt && prev >= 0) chk(r, int'(int'(issue_tid) != prev), 1);
      prev = int'(issue_tid);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 issue_valid after reset", int'(issue_valid), 0);
    chk("R1 create_done after reset", int'(create_done), 0);
  endtask

  task automatic t_create_all();
    for (int i = 0; i < NTHR; i++) begin
      create_expect("R1 R2 create order", 1'b0, i);
      @(negedge clk);
      chk("R2 created not issuable", int'(issue_valid), 0);
    end
    create_expect("R7 create on empty pool", 1'b1, 0);
  endtask

  task automatic t_rotate();
    int prev = -1;
    enq_cmd(0); enq_cmd(1); enq_cmd(2);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R3 issue every cycle", int'(issue_valid), 1);
      if (prev >= 0) chk("R3 enqueue order", int'(issue_tid), (prev + 1) % 3);
      prev = int'(issue_tid);
    end
  endtask

  task automatic t_stall();
    wait_for(0);
    in_pipe[1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 stalled thread not offered", int'(issue_valid), 0);
    end
    in_pipe[1] = 1'b0;
    #1;
    chk("R4 retry same thread valid", int'(issue_valid), 1);
    chk("R4 retry same thread id", int'(issue_tid), 1);
  endtask

  task automatic t_delete_current();
    wait_for(0);
    in_pipe[1] = 1'b1;
    @(posedge clk); #1 del_req = 1'b1; del_tid = TW'(1);
    @(posedge clk); #1 del_req = 1'b0; in_pipe = '0;
    @(negedge clk);
    chk("R6 idle on deleted entry", int'(issue_valid), 0);
    @(negedge clk);
    chk("R6 successor valid", int'(issue_valid), 1);
    chk("R6 successor id", int'(issue_tid), 2);
    check_rot("R5 deleted thread gone", 8'b0000_0101, 1'b1);
  endtask

  task automatic t_free_order();
    del_cmd(5); del_cmd(4);
    create_expect("R5 pool order first", 1'b0, 1);
    create_expect("R5 pool order second", 1'b0, 5);
    create_expect("R5 pool order third", 1'b0, 4);
    create_expect("R7 pool drained", 1'b1, 0);
  endtask

  task automatic t_ignored();
    del_cmd(7);
    del_cmd(7);
    enq_cmd(7);
    enq_cmd(2);
    check_rot("R10 illegal commands ignored", 8'b0000_0101, 1'b1);
    create_expect("R10 single push of freed id", 1'b0, 7);
    create_expect("R10 no double push", 1'b1, 0);
  endtask

  task automatic t_priority();
    @(posedge clk); #1 del_req = 1'b1; del_tid = TW'(0); create_req = 1'b1;
    @(posedge clk); #1 del_req = 1'b0; create_req = 1'b0;
    chk("R9 losing create gives no pulse", int'(create_done), 0);
    check_rot("R9 delete acted", 8'b0000_0100, 1'b0);
    create_expect("R9 deleted id returned", 1'b0, 0);
  endtask

  task automatic t_empty();
    del_cmd(2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 empty rotation idle", int'(issue_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_create_all();
    t_rotate();
    t_stall();
    t_delete_current();
    t_free_order();
    t_ignored();
    t_priority();
    t_empty();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule